// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block holds the slot control and slot status registers of a downstream port that accepts hot-plug. Software writes the control register to issue commands. It writes the status register to acknowledge events. Hardware event inputs set sticky status bits: attention button, power fault, latch change and presence change. An interrupt leaves the block whenever the enabled-and-pending condition of the slot changes.

Each write to the control register is one command. The command takes effect in the cycle of the write, and the command-completed status bit is then set. The write can also do two things. A set interlock bit flips the interlock status. A change into the power-off state while a device is present drops the presence state and flags a presence change, so that upper layers can detach the device. The interrupt is either a legacy level that tracks the aggregate flag, or a single-cycle message pulse sent on each change of that flag. The choice is made by a mode input.

Top module: `hp_slot_ctrl`

## Requirements
- R1: Control layout: bits 4:0 enable the events, bit 5 is the hot-plug interrupt enable, bits 7:6 hold the attention indicator, bits 9:8 hold the power indicator, bit 10 is power-controller-off, bit 11 is the interlock command, and bits 15:12 read 0. Indicator codes are 01 on, 10 blink and 11 off. The aggregate flag is bit 5 AND the OR over bits 4:0 of (status event bits AND control enable bits).
- R2: A notification occurs only when the aggregate flag changes. With `msi_en` high, each change gives a `msg_pulse` that lasts exactly one cycle and `irq_level` stays 0. With `msi_en` low, `irq_level` equals the flag in the cycle after the update and `msg_pulse` stays 0.
- R3: Setting an event status bit that is already set produces no new message pulse.
- R4: Every control write sets the command-completed status bit (status bit 4) in the cycle after the write, whichever fields the write changes.
- R5: The interlock command bit always reads 0. Writing it as 1 flips the interlock status (status bit 7).
- R6: A control write that has power-off set and power indicator 11, while presence (status bit 6) is 1 and the previous control value was not in that state, clears presence and sets presence-changed (status bit 3). A repeat of that write does not.
- R7: Synchronous reset sets control to 0x00C0 (attention indicator off, everything else 0). It clears all status event bits and the interlock status, loads presence from `present_in`, and drives both interrupt outputs to 0.
- R8: Status event bits 4:0 are write-1-to-clear. If a clear targets an event bit that is 0 in `sta_seen`, the write is dropped and all event bits keep their pre-write values.
- R9: In legacy mode, a status write that clears the last enabled pending event drops `irq_level` in the next cycle.
- R10: The event inputs set these status bits: button sets bit 0, power fault sets bit 1, latch change sets bit 2, presence change sets bit 3. A presence change also loads status bit 6 from `present_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_en | input | 1 | Selects message interrupts instead of the legacy level |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data |
| sta_we | input | 1 | Status write strobe (write-1-to-clear) |
| sta_clr | input | 5 | Event bits to clear |
| sta_seen | input | 5 | Event bits as last read by software |
| ev_button | input | 1 | Attention button pressed |
| ev_pwr_fault | input | 1 | Power fault detected |
| ev_latch | input | 1 | Retention latch changed |
| ev_presence | input | 1 | Presence changed |
| present_in | input | 1 | Current presence detect level |
| slot_ctl | output | 16 | Control register read value |
| slot_sta | output | 16 | Status register read value |
| irq_level | output | 1 | Legacy interrupt level |
| msg_pulse | output | 1 | Single-cycle message interrupt request |

## Verification
Assertions check on every cycle that:
- a control write is followed by command-completed;
- the interlock status flips after an interlock command;
- a detected power-off leaves presence cleared and presence-changed set;
- a stale status clear never drops an event bit;
- no message pulse appears in legacy mode.

Only the bench scenarios show the following:
- the aggregate flag's effect on `irq_level`;
- that re-setting a pending event gives no second pulse;
- the negative case of a repeated power-off write;
- the exact reset values.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    localparam int REG_W = 16;
    localparam int EV_W  = 5;

    localparam int EV_BTN    = 0;
    localparam int EV_PFAULT = 1;
    localparam int EV_LATCH  = 2;
    localparam int EV_PRES   = 3;
    localparam int EV_CMD    = 4;

    localparam logic [1:0] IND_ON    = 2'b01;
    localparam logic [1:0] IND_BLINK = 2'b10;
    localparam logic [1:0] IND_OFF   = 2'b11;

    typedef struct packed {
        logic [3:0]      rsvd;
        logic            ilock_cmd;
        logic            pwr_off;
        logic [1:0]      pwr_ind;
        logic [1:0]      attn_ind;
        logic            hp_ie;
        logic [EV_W-1:0] ev_en;
    } slot_ctl_t;

    typedef struct packed {
        logic [7:0]      rsvd;
        logic            ilock;
        logic            pres;
        logic            rsvd5;
        logic [EV_W-1:0] ev;
    } slot_sta_t;

    function automatic slot_ctl_t ctl_reset_value();
        slot_ctl_t c;
        c          = '0;
        c.attn_ind = IND_OFF;
        return c;
    endfunction

    function automatic slot_ctl_t ctl_sanitize(slot_ctl_t w);
        slot_ctl_t c;
        c           = w;
        c.rsvd      = '0;
        c.ilock_cmd = 1'b0;
        return c;
    endfunction

    function automatic logic in_power_off(slot_ctl_t c);
        return c.pwr_off && (c.pwr_ind == IND_OFF);
    endfunction

    function automatic logic aggregate(slot_ctl_t c, slot_sta_t s);
        return c.hp_ie && (|(c.ev_en & s.ev));
    endfunction
endpackage

// File: rtl/hp_slot_cmd.sv
module hp_slot_cmd
    import hp_slot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctl_we,
    input  slot_ctl_t ctl_wdata,
    input  logic      pres_q,
    output slot_ctl_t ctl_q,
    output slot_ctl_t ctl_next,
    output logic      cmd_issue,
    output logic      ilock_toggle,
    output logic      poweroff_hit
);
    always_comb begin
        ctl_next     = ctl_we ? ctl_sanitize(ctl_wdata) : ctl_q;
        cmd_issue    = ctl_we;
        ilock_toggle = ctl_we && ctl_wdata.ilock_cmd;
        poweroff_hit = ctl_we && pres_q && in_power_off(ctl_wdata)
                       && !in_power_off(ctl_q);
        if (rst) ctl_next = ctl_reset_value();
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_next;
    end

    // R5: interlock command never reads back as set
    assert_ilock_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ctl_q.ilock_cmd == 1'b0));
endmodule

// File: rtl/hp_slot_status.sv
module hp_slot_status
    import hp_slot_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sta_we,
    input  logic [EV_W-1:0] sta_clr,
    input  logic [EV_W-1:0] sta_seen,
    input  logic            ev_button,
    input  logic            ev_pwr_fault,
    input  logic            ev_latch,
    input  logic            ev_presence,
    input  logic            present_in,
    input  logic            cmd_issue,
    input  logic            ilock_toggle,
    input  logic            poweroff_hit,
    output slot_sta_t       sta_q,
    output slot_sta_t       sta_next
);
    logic stale_clear;
    assign stale_clear = sta_we && (|(sta_clr & ~sta_seen));

    always_comb begin
        sta_next = sta_q;
        if (sta_we && !stale_clear) sta_next.ev = sta_q.ev & ~sta_clr;
        if (ilock_toggle) sta_next.ilock = ~sta_q.ilock;
        if (poweroff_hit) begin
            sta_next.pres         = 1'b0;
            sta_next.ev[EV_PRES]  = 1'b1;
        end
        if (ev_presence) begin
            sta_next.pres         = present_in;
            sta_next.ev[EV_PRES]  = 1'b1;
        end
        if (ev_button)    sta_next.ev[EV_BTN]    = 1'b1;
        if (ev_pwr_fault) sta_next.ev[EV_PFAULT] = 1'b1;
        if (ev_latch)     sta_next.ev[EV_LATCH]  = 1'b1;
        if (cmd_issue)    sta_next.ev[EV_CMD]    = 1'b1;
        if (rst) begin
            sta_next      = '0;
            sta_next.pres = present_in;
        end
    end

    always_ff @(posedge clk) begin
        sta_q <= sta_next;
    end

    assert_cmd_done_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_issue |=> sta_q.ev[EV_CMD]);

    assert_ilock_flip_R5: assert property (@(posedge clk) disable iff (rst)
        ilock_toggle |=> (sta_q.ilock != $past(sta_q.ilock)));

    assert_poweroff_R6: assert property (@(posedge clk) disable iff (rst)
        (poweroff_hit && !ev_presence) |=> (!sta_q.pres && sta_q.ev[EV_PRES]));

    assert_stale_keep_R8: assert property (@(posedge clk) disable iff (rst)
        stale_clear |=> (($past(sta_q.ev) & ~sta_q.ev) == '0));
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
    import hp_slot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      msi_en,
    input  slot_ctl_t ctl_next,
    input  slot_sta_t sta_next,
    output logic      irq_level,
    output logic      msg_pulse
);
    logic flag_q;
    logic flag_nx;

    assign flag_nx = aggregate(ctl_next, sta_next);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q    <= 1'b0;
            msg_pulse <= 1'b0;
            irq_level <= 1'b0;
        end else begin
            flag_q    <= flag_nx;
            msg_pulse <= msi_en && (flag_nx != flag_q);
            irq_level <= !msi_en && flag_nx;
        end
    end

    assert_no_msg_legacy_R2: assert property (@(posedge clk) disable iff (rst)
        !msi_en |=> !msg_pulse);

    assert_no_level_msi_R2: assert property (@(posedge clk) disable iff (rst)
        msi_en |=> !irq_level);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             msi_en,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             sta_we,
    input  logic [EV_W-1:0]  sta_clr,
    input  logic [EV_W-1:0]  sta_seen,
    input  logic             ev_button,
    input  logic             ev_pwr_fault,
    input  logic             ev_latch,
    input  logic             ev_presence,
    input  logic             present_in,
    output logic [REG_W-1:0] slot_ctl,
    output logic [REG_W-1:0] slot_sta,
    output logic             irq_level,
    output logic             msg_pulse
);
    slot_ctl_t ctl_q, ctl_next;
    slot_sta_t sta_q, sta_next;
    logic      cmd_issue, ilock_toggle, poweroff_hit;

    hp_slot_cmd u_cmd (
        .clk          (clk),
        .rst          (rst),
        .ctl_we       (ctl_we),
        .ctl_wdata    (slot_ctl_t'(ctl_wdata)),
        .pres_q       (sta_q.pres),
        .ctl_q        (ctl_q),
        .ctl_next     (ctl_next),
        .cmd_issue    (cmd_issue),
        .ilock_toggle (ilock_toggle),
        .poweroff_hit (poweroff_hit)
    );

    hp_slot_status u_status (
        .clk          (clk),
        .rst          (rst),
        .sta_we       (sta_we),
        .sta_clr      (sta_clr),
        .sta_seen     (sta_seen),
        .ev_button    (ev_button),
        .ev_pwr_fault (ev_pwr_fault),
        .ev_latch     (ev_latch),
        .ev_presence  (ev_presence),
        .present_in   (present_in),
        .cmd_issue    (cmd_issue),
        .ilock_toggle (ilock_toggle),
        .poweroff_hit (poweroff_hit),
        .sta_q        (sta_q),
        .sta_next     (sta_next)
    );

    hp_slot_notify u_notify (
        .clk       (clk),
        .rst       (rst),
        .msi_en    (msi_en),
        .ctl_next  (ctl_next),
        .sta_next  (sta_next),
        .irq_level (irq_level),
        .msg_pulse (msg_pulse)
    );

    assign slot_ctl = ctl_q;
    assign slot_sta = sta_q;

    // R10: a button event is latched into status bit 0
    assert_button_latch_R10: assert property (@(posedge clk) disable iff (rst)
        ev_button |=> slot_sta[EV_BTN]);
endmodule

// File: tb/tb_hp_slot_ctrl.sv
module tb_hp_slot_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msi_en = 1'b0;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        sta_we = 1'b0;
    logic [4:0]  sta_clr = '0;
    logic [4:0]  sta_seen = '0;
    logic        ev_button = 1'b0, ev_pwr_fault = 1'b0, ev_latch = 1'b0, ev_presence = 1'b0;
    logic        present_in = 1'b0;
    logic [15:0] slot_ctl, slot_sta;
    logic        irq_level, msg_pulse;

    hp_slot_ctrl dut (
        .clk(clk), .rst(rst), .msi_en(msi_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .sta_we(sta_we), .sta_clr(sta_clr), .sta_seen(sta_seen),
        .ev_button(ev_button), .ev_pwr_fault(ev_pwr_fault), .ev_latch(ev_latch),
        .ev_presence(ev_presence), .present_in(present_in),
        .slot_ctl(slot_ctl), .slot_sta(slot_sta), .irq_level(irq_level), .msg_pulse(msg_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string       tag;
        int          due;
        logic [15:0] c;
        logic [15:0] s;
        logic        irq;
        logic        msg;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   timed_out = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop expected items as their cycle arrives
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t it;
            it = q.pop_front();
            n_checks++;
            if (slot_ctl !== it.c || slot_sta !== it.s || irq_level !== it.irq || msg_pulse !== it.msg) begin
                n_fail++;
                $display("FAIL %s: ctl=%h sta=%h irq=%b msg=%b expected ctl=%h sta=%h irq=%b msg=%b",
                         it.tag, slot_ctl, slot_sta, irq_level, msg_pulse, it.c, it.s, it.irq, it.msg);
            end
        end
    end

    // driver: inputs for one cycle, applied just after a rising edge
    task automatic apply(input logic r, input logic m, input logic cw, input logic [15:0] cd,
                         input logic sw, input logic [4:0] clr, input logic [4:0] seen,
                         input logic [3:0] ev, input logic pres);
        @(posedge clk);
        #1;
        rst = r; msi_en = m; ctl_we = cw; ctl_wdata = cd;
        sta_we = sw; sta_clr = clr; sta_seen = seen;
        ev_button = ev[0]; ev_pwr_fault = ev[1]; ev_latch = ev[2]; ev_presence = ev[3];
        present_in = pres;
    endtask

    task automatic expect_out(input string tag, input logic [15:0] c, input logic [15:0] s,
                              input logic irq, input logic msg);
        exp_t it;
        it.tag = tag; it.due = cyc + 1; it.c = c; it.s = s; it.irq = irq; it.msg = msg;
        q.push_back(it);
    endtask

    initial begin
        apply(1, 0, 0, 16'h0, 0, 5'h0, 5'h0, 4'h0, 0);
        apply(1, 0, 0, 16'h0, 0, 5'h0, 5'h0, 4'h0, 0);
        expect_out("R7 reset state", 16'h00C0, 16'h0000, 0, 0);
        apply(0, 0, 0, 16'h0, 0, 5'h0, 5'h0, 4'b1000, 1);
        expect_out("R10 presence event", 16'h00C0, 16'h0048, 0, 0);
        apply(0, 0, 1, 16'h00E1, 0, 5'h0, 5'h0, 4'h0, 1);
        expect_out("R4 command completed", 16'h00E1, 16'h0058, 0, 0);
        apply(0, 0, 0, 16'h0, 0, 5'h0, 5'h0, 4'b0001, 1);
        expect_out("R1 button raises legacy irq", 16'h00E1, 16'h0059, 1, 0);
        apply(0, 0, 0, 16'h0, 0, 5'h0, 5'h0, 4'b0001, 1);
        expect_out("R3 repeat button", 16'h00E1, 16'h0059, 1, 0);
        apply(0, 0, 0, 16'h0, 1, 5'h01, 5'h19, 4'h0, 1);
        expect_out("R9 clear drops irq", 16'h00E1, 16'h0058, 0, 0);
        apply(0, 0, 0, 16'h0, 1, 5'h1F, 5'h00, 4'h0, 1);
        expect_out("R8 stale clear restored", 16'h00E1, 16'h0058, 0, 0);
        apply(0, 0, 0, 16'h0, 1, 5'h18, 5'h18, 4'h0, 1);
        expect_out("R8 normal clear", 16'h00E1, 16'h0040, 0, 0);
        apply(0, 0, 1, 16'h08E1, 0, 5'h0, 5'h0, 4'h0, 1);
        expect_out("R5 interlock on", 16'h00E1, 16'h00D0, 0, 0);
        apply(0, 0, 1, 16'h08E1, 0, 5'h0, 5'h0, 4'h0, 1);
        expect_out("R5 interlock off", 16'h00E1, 16'h0050, 0, 0);
        apply(0, 1, 1, 16'h00F1, 0, 5'h0, 5'h0, 4'h0, 1);
        expect_out("R2 message on rise", 16'h00F1, 16'h0050, 0, 1);
        apply(0, 1, 0, 16'h0, 0, 5'h0, 5'h0, 4'h0, 1);
        expect_out("R2 single-cycle pulse", 16'h00F1, 16'h0050, 0, 0);
        apply(0, 1, 1, 16'h00F1, 0, 5'h0, 5'h0, 4'h0, 1);
        expect_out("R3 cmd-done already set", 16'h00F1, 16'h0050, 0, 0);
        apply(0, 1, 0, 16'h0, 1, 5'h10, 5'h10, 4'h0, 1);
        expect_out("R2 message on fall", 16'h00F1, 16'h0040, 0, 1);
        apply(0, 1, 1, 16'h07F1, 0, 5'h0, 5'h0, 4'h0, 1);
        expect_out("R6 power-off detected", 16'h07F1, 16'h0018, 0, 1);
        apply(0, 1, 0, 16'h0, 0, 5'h0, 5'h0, 4'b1000, 1);
        expect_out("R10 reinsert", 16'h07F1, 16'h0058, 0, 0);
        apply(0, 1, 1, 16'h07F1, 0, 5'h0, 5'h0, 4'h0, 1);
        expect_out("R6 repeat not detected", 16'h07F1, 16'h0058, 0, 0);
        apply(0, 1, 0, 16'h0, 0, 5'h0, 5'h0, 4'b0110, 1);
        expect_out("R10 fault and latch", 16'h07F1, 16'h005E, 0, 0);
        apply(0, 0, 0, 16'h0, 0, 5'h0, 5'h0, 4'h0, 1);
        expect_out("R2 legacy level follows flag", 16'h07F1, 16'h005E, 1, 0);
        apply(1, 0, 0, 16'h0, 0, 5'h0, 5'h0, 4'h0, 1);
        expect_out("R7 reset with device present", 16'h00C0, 16'h0040, 0, 0);
        apply(0, 0, 0, 16'h0, 0, 5'h0, 5'h0, 4'h0, 1);
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        repeat (2000) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            timed_out = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
    end

    initial begin
        wait (done || timed_out);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule